// File: doc/BRIEF.md
# Eight-bit ALU with condition flags

This block is the arithmetic and logic datapath of a small byte-wide controller. It takes two operands, an operation code, a carry-use request and a shift or rotate amount. It produces an 8-bit result and keeps a four-bit flag register that holds zero, carry, overflow and negative. Both outputs are registered, and they change only on a clock edge where `op_valid` is high.

Subtraction and compare treat carry as a borrow. One further operation rotates the operand right and then masks it so that bit 0 is always clear. This gives an even offset into a table of two-byte jump entries.

A condition selector turns a three-bit code into one testable bit. Four codes pick the stored flags. The other four pick status lines that an attached serial transceiver drives. Instruction decode and the register file are outside the block. The decoder feeds operands to this block and reads the selected condition back for its branch decisions.

Top module: `flag_alu8`

## Requirements
- R1: After reset, `result` is 0x00 and `flags` is 0x0. Flag positions are: bit 0 zero (Z), bit 1 carry (C), bit 2 overflow (V), bit 3 negative (N).
- R2: Opcode 0 (add) stores a + b + cin. C is set when the unsigned sum reaches 0x100. V is set when a and b have the same sign and the result sign differs.
- R3: Opcode 1 (subtract) stores a − b − cin. C is set when a < b + cin, taken unsigned. V is set when a and b differ in sign and the result sign differs from a.
- R4: cin is 1 only when `use_carry` is high and the stored C flag is 1. Otherwise cin is 0.
- R5: Opcode 2 (compare) updates Z, C, V and N exactly as subtract does, and leaves `result` unchanged.
- R6: Opcodes 3 (AND), 4 (OR), 5 (XOR) and 6 (complement of a) store their result and update only Z and N. C and V keep their values.
- R7: Every operation that updates Z and N sets Z when the 8-bit result is zero and sets N from result bit 7. These operations are opcodes 0, 1, 3 to 9, and 2 using the value it computes.
- R8: Opcode 8 (logical shift right by `amount` = n) and opcode 9 (rotate right by n) set C to operand bit n−1. They update Z and N and keep V. When n = 0, the result equals a and C becomes 0.
- R9: Opcode 7 (logical shift left by n) sets C to operand bit 8−n. It updates Z and N and keeps V. When n = 0, the result equals a and C becomes 0.
- R10: Opcode 10 (rotate-and-mask) rotates a right by `amount`, then ANDs the value with (0xFF >> `mask_cnt`) & 0xFE. All four flags stay unchanged.
- R11: `cond_bit` is combinational. For `cond_sel` 0 to 3 it returns Z, C, V and N. For `cond_sel` 4 to 7 it returns `xcvr_stat` bits 0 to 3, which are: receiver active, receiver error, data available, transmit FIFO full.
- R12: When `op_valid` is low, or when the opcode is 11 to 15, `result` and `flags` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Performs the operation on this edge |
| opcode | input | 4 | Operation code (see R2–R12) |
| opnd_a | input | 8 | First operand (minuend, shifted value) |
| opnd_b | input | 8 | Second operand |
| use_carry | input | 1 | Requests the stored carry as carry-in |
| amount | input | 3 | Shift or rotate distance |
| mask_cnt | input | 3 | Mask count for rotate-and-mask |
| cond_sel | input | 3 | Condition selector code |
| xcvr_stat | input | 4 | External transceiver status bits |
| result | output | 8 | Registered result |
| flags | output | 4 | Flag register {N,V,C,Z} |
| cond_bit | output | 1 | Selected condition |

## Verification
Two functions meet in one cycle. In a carry-using add or subtract, the stored C flag is both read as carry-in and overwritten by the new carry on the same edge. Runs of back-to-back arithmetic with `use_carry` high provoke this, including borrow chains at 0x00 and 0xFF. The bench model takes its carry-in from the flag value before the edge and compares each new result and flag set. The condition selector is also read in the cycle after every update, so a stale flag would show up in `cond_bit`.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_CMP   = 4'd2,
      OP_AND   = 4'd3,
      OP_OR    = 4'd4,
      OP_XOR   = 4'd5,
      OP_NOT   = 4'd6,
      OP_SHL   = 4'd7,
      OP_SHR   = 4'd8,
      OP_ROR   = 4'd9,
      OP_RMASK = 4'd10
   } alu_op_e;

   localparam int FL_Z = 0;
   localparam int FL_C = 1;
   localparam int FL_V = 2;
   localparam int FL_N = 3;
   localparam int FLAG_W = 4;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              carry,
   output logic              ovf
);
   localparam int EXT_W = DATA_W + 1;

   logic [EXT_W-1:0] a_ext, b_ext, c_ext, sum_ext, rhs_ext;

   always_comb begin
      a_ext   = {1'b0, a};
      b_ext   = {1'b0, b};
      c_ext   = {{DATA_W{1'b0}}, cin};
      rhs_ext = b_ext + c_ext;
      if (sub) begin
         sum_ext = a_ext - rhs_ext;
         carry   = (a_ext < rhs_ext);
         ovf     = (a[DATA_W-1] != b[DATA_W-1]) && (sum_ext[DATA_W-1] != a[DATA_W-1]);
      end else begin
         sum_ext = a_ext + rhs_ext;
         carry   = sum_ext[DATA_W];
         ovf     = (a[DATA_W-1] == b[DATA_W-1]) && (sum_ext[DATA_W-1] != a[DATA_W-1]);
      end
      res = sum_ext[DATA_W-1:0];
   end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
   parameter int DATA_W = 8,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] a,
   input  logic [AMT_W-1:0]  amt,
   input  logic [AMT_W-1:0]  mcnt,
   output logic [DATA_W-1:0] shl_res,
   output logic              shl_c,
   output logic [DATA_W-1:0] shr_res,
   output logic              shr_c,
   output logic [DATA_W-1:0] ror_res,
   output logic              ror_c,
   output logic [DATA_W-1:0] rmask_res
);
   localparam int DBL_W = 2 * DATA_W;

   logic [DATA_W:0]   left_ext;
   logic [DATA_W:0]   right_ext;
   logic [DBL_W-1:0]  dbl;
   logic [DATA_W-1:0] mask;

   always_comb begin
      left_ext  = {1'b0, a} << amt;
      shl_res   = left_ext[DATA_W-1:0];
      shl_c     = left_ext[DATA_W];

      right_ext = {a, 1'b0} >> amt;
      shr_res   = right_ext[DATA_W:1];
      shr_c     = right_ext[0];

      dbl       = {a, a} >> amt;
      ror_res   = dbl[DATA_W-1:0];
      ror_c     = right_ext[0];

      mask      = ({DATA_W{1'b1}} >> mcnt) & ~{{(DATA_W-1){1'b0}}, 1'b1};
      rmask_res = ror_res & mask;
   end
endmodule

// File: rtl/alu8_cond_sel.sv
module alu8_cond_sel #(
   parameter int N_FLAG = 4,
   parameter int N_STAT = 4,
   localparam int N_COND = N_FLAG + N_STAT,
   localparam int SEL_W  = $clog2(N_COND)
) (
   input  logic [N_FLAG-1:0] flag_i,
   input  logic [N_STAT-1:0] stat_i,
   input  logic [SEL_W-1:0]  sel,
   output logic              bit_o
);
   logic [N_COND-1:0] pool;

   for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
      assign pool[i] = flag_i[i];
   end
   for (genvar j = 0; j < N_STAT; j++) begin : g_stat
      assign pool[N_FLAG + j] = stat_i[j];
   end

   assign bit_o = pool[sel];
endmodule

// File: rtl/flag_alu8.sv
module flag_alu8
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int N_STAT = 4,
   localparam int AMT_W = $clog2(DATA_W),
   localparam int SEL_W = $clog2(FLAG_W + N_STAT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        opcode,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              use_carry,
   input  logic [AMT_W-1:0]  amount,
   input  logic [AMT_W-1:0]  mask_cnt,
   input  logic [SEL_W-1:0]  cond_sel,
   input  logic [N_STAT-1:0] xcvr_stat,
   output logic [DATA_W-1:0] result,
   output logic [FLAG_W-1:0] flags,
   output logic              cond_bit
);
   if (DATA_W < 2 || (1 << AMT_W) != DATA_W) begin : g_bad_width
      $error("flag_alu8: DATA_W must be a power of two and at least 2");
   end
   if (FLAG_W + N_STAT != (1 << SEL_W)) begin : g_bad_stat
      $error("flag_alu8: flag and status count must fill the selector space");
   end

   alu_op_e           op;
   logic              cin;
   logic [DATA_W-1:0] as_res;
   logic              as_c, as_v;
   logic [DATA_W-1:0] shl_res, shr_res, ror_res, rmask_res;
   logic              shl_c, shr_c, ror_c;
   logic [DATA_W-1:0] res_d, res_q;
   logic [FLAG_W-1:0] fl_d, fl_q;
   logic [DATA_W-1:0] nz_src;
   logic              upd_nz;

   assign op  = alu_op_e'(opcode);
   assign cin = use_carry & fl_q[FL_C];

   alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a(opnd_a), .b(opnd_b), .sub(op != OP_ADD), .cin(cin),
      .res(as_res), .carry(as_c), .ovf(as_v)
   );

   alu8_shifter #(.DATA_W(DATA_W)) u_shift (
      .a(opnd_a), .amt(amount), .mcnt(mask_cnt),
      .shl_res(shl_res), .shl_c(shl_c),
      .shr_res(shr_res), .shr_c(shr_c),
      .ror_res(ror_res), .ror_c(ror_c),
      .rmask_res(rmask_res)
   );

   always_comb begin
      res_d  = res_q;
      fl_d   = fl_q;
      nz_src = '0;
      upd_nz = 1'b0;
      if (op_valid) begin
         unique case (op)
            OP_ADD, OP_SUB: begin
               res_d = as_res; nz_src = as_res; upd_nz = 1'b1;
               fl_d[FL_C] = as_c; fl_d[FL_V] = as_v;
            end
            OP_CMP: begin
               nz_src = as_res; upd_nz = 1'b1;
               fl_d[FL_C] = as_c; fl_d[FL_V] = as_v;
            end
            OP_AND: begin res_d = opnd_a & opnd_b; nz_src = res_d; upd_nz = 1'b1; end
            OP_OR:  begin res_d = opnd_a | opnd_b; nz_src = res_d; upd_nz = 1'b1; end
            OP_XOR: begin res_d = opnd_a ^ opnd_b; nz_src = res_d; upd_nz = 1'b1; end
            OP_NOT: begin res_d = ~opnd_a;         nz_src = res_d; upd_nz = 1'b1; end
            OP_SHL: begin
               res_d = shl_res; nz_src = shl_res; upd_nz = 1'b1; fl_d[FL_C] = shl_c;
            end
            OP_SHR: begin
               res_d = shr_res; nz_src = shr_res; upd_nz = 1'b1; fl_d[FL_C] = shr_c;
            end
            OP_ROR: begin
               res_d = ror_res; nz_src = ror_res; upd_nz = 1'b1; fl_d[FL_C] = ror_c;
            end
            OP_RMASK: res_d = rmask_res;
            default: ;
         endcase
         if (upd_nz) begin
            fl_d[FL_Z] = (nz_src == '0);
            fl_d[FL_N] = nz_src[DATA_W-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         fl_q  <= '0;
      end else begin
         res_q <= res_d;
         fl_q  <= fl_d;
      end
   end

   alu8_cond_sel #(.N_FLAG(FLAG_W), .N_STAT(N_STAT)) u_cond (
      .flag_i(fl_q), .stat_i(xcvr_stat), .sel(cond_sel), .bit_o(cond_bit)
   );

   assign result = res_q;
   assign flags  = fl_q;
endmodule

// File: rtl/flag_alu8_chk.sv
module flag_alu8_chk
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [3:0]        opcode,
   input logic [DATA_W-1:0] result,
   input logic [FLAG_W-1:0] flags
);
   logic nz_op;
   logic logic_op;
   assign nz_op = op_valid && (opcode == OP_ADD || opcode == OP_SUB ||
                  (opcode >= OP_AND && opcode <= OP_ROR));
   assign logic_op = op_valid && opcode >= OP_AND && opcode <= OP_NOT;

   a_r5_cmp_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opcode == OP_CMP) |=> $stable(result));

   a_r6_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
      logic_op |=> $stable(flags[FL_V:FL_C]));

   a_r7_zero_neg: assert property (@(posedge clk) disable iff (!rst_n)
      nz_op |=> (flags[FL_Z] == (result == '0)) && (flags[FL_N] == result[DATA_W-1]));

   a_r10_even_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opcode == OP_RMASK) |=> (!result[0] && $stable(flags)));

   a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid || opcode > OP_RMASK) |=> ($stable(result) && $stable(flags)));
endmodule

bind flag_alu8 flag_alu8_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
   .result(result), .flags(flags)
);

// File: tb/tb_flag_alu8.sv
module tb_flag_alu8;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [3:0] opcode = '0;
   logic [7:0] opnd_a = '0, opnd_b = '0;
   logic       use_carry = 1'b0;
   logic [2:0] amount = '0, mask_cnt = '0, cond_sel = '0;
   logic [3:0] xcvr_stat = '0;
   logic [7:0] result;
   logic [3:0] flags;
   logic       cond_bit;

   int vectors = 0;
   int miscompares = 0;
   logic [7:0] e_res = '0;
   logic [3:0] e_fl = '0;

   always #4 clk = ~clk;

   flag_alu8 dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .use_carry(use_carry),
      .amount(amount), .mask_cnt(mask_cnt), .cond_sel(cond_sel),
      .xcvr_stat(xcvr_stat), .result(result), .flags(flags), .cond_bit(cond_bit)
   );

   task automatic check(string req, logic [11:0] act, logic [11:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %03h expected %03h", req, act, exp);
      end
   endtask

   task automatic model(bit v, int op, logic [7:0] a, logic [7:0] b, bit uc, int n, int m);
      logic cin, c;
      logic [7:0] r;
      int s;
      if (!v || op > 10) return;
      cin = uc & e_fl[1];
      c = 1'b0;
      r = 8'h00;
      case (op)
         0: begin
            s = int'(a) + int'(b) + int'(cin); r = s[7:0];
            e_fl[1] = (s >= 256); e_fl[2] = (a[7] == b[7]) && (r[7] != a[7]);
         end
         1, 2: begin
            r = a - b - {7'd0, cin};
            e_fl[1] = (int'(a) < int'(b) + int'(cin));
            e_fl[2] = (a[7] != b[7]) && (r[7] != a[7]);
         end
         3: r = a & b;
         4: r = a | b;
         5: r = a ^ b;
         6: r = ~a;
         7: begin r = a << n; c = (n == 0) ? 1'b0 : a[8-n]; e_fl[1] = c; end
         8: begin r = a >> n; c = (n == 0) ? 1'b0 : a[n-1]; e_fl[1] = c; end
         9, 10: begin
            r = (n == 0) ? a : ((a >> n) | (a << (8 - n)));
            c = (n == 0) ? 1'b0 : a[n-1];
            if (op == 9) e_fl[1] = c;
            else r = r & ((8'hFF >> m) & 8'hFE);
         end
         default: ;
      endcase
      if (op != 10) begin
         e_fl[0] = (r == 8'h00);
         e_fl[3] = r[7];
      end
      if (op != 2) e_res = r;
   endtask

   function automatic string req_of(bit v, int op);
      if (!v || op > 10) return "R12";
      case (op)
         0: return "R2/R4";
         1: return "R3/R4";
         2: return "R5";
         3, 4, 5, 6: return "R6/R7";
         7: return "R9";
         8, 9: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic apply(bit v, int op, logic [7:0] a, logic [7:0] b, bit uc, int n, int m);
      logic [3:0] st;
      logic [2:0] cs;
      logic exp_c;
      op_valid = v; opcode = op[3:0]; opnd_a = a; opnd_b = b;
      use_carry = uc; amount = n[2:0]; mask_cnt = m[2:0];
      @(posedge clk);
      model(v, op, a, b, uc, n, m);
      @(negedge clk);
      op_valid = 1'b0;
      check(req_of(v, op), {result, flags}, {e_res, e_fl});
      st = 4'($urandom);
      cs = 3'($urandom);
      xcvr_stat = st; cond_sel = cs;
      #1;
      exp_c = (cs < 4) ? e_fl[cs[1:0]] : st[cs[1:0]];
      check("R11", {11'd0, cond_bit}, {11'd0, exp_c});
   endtask

   initial begin : watchdog
      #1000000;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd2024));
      #3;
      check("R1", {result, flags}, 12'h000);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {result, flags}, 12'h000);
      apply(1, 0, 8'h7F, 8'h01, 0, 0, 0);   // R2 overflow, N
      apply(1, 0, 8'hFF, 8'h01, 0, 0, 0);   // R2 carry, Z
      apply(1, 0, 8'h10, 8'h20, 1, 0, 0);   // R4 carry-in used
      apply(1, 0, 8'h10, 8'h20, 0, 0, 0);   // R4 carry-in ignored
      apply(1, 1, 8'h00, 8'h01, 0, 0, 0);   // R3 borrow
      apply(1, 1, 8'h05, 8'h04, 1, 0, 0);   // R3 with borrow-in gives zero
      apply(1, 1, 8'h80, 8'h01, 0, 0, 0);   // R3 overflow
      apply(1, 1, 8'hFF, 8'hFF, 1, 0, 0);   // R3 borrow chain, carry-in 0
      apply(1, 2, 8'h33, 8'h44, 0, 0, 0);   // R5 result kept
      apply(1, 3, 8'hF0, 8'h0F, 0, 0, 0);   // R6 zero, C/V kept
      apply(1, 6, 8'h00, 8'h00, 0, 0, 0);   // R6 complement
      apply(1, 8, 8'h81, 8'h00, 0, 1, 0);   // R8 shift out bit 0
      apply(1, 8, 8'h81, 8'h00, 0, 0, 0);   // R8 amount 0
      apply(1, 9, 8'h81, 8'h00, 0, 7, 0);   // R8 rotate
      apply(1, 7, 8'h81, 8'h00, 0, 1, 0);   // R9 shift left
      apply(1, 7, 8'h40, 8'h00, 0, 0, 0);   // R9 amount 0
      apply(1, 10, 8'hFF, 8'h00, 0, 3, 0);  // R10 mask 0xFE
      apply(1, 10, 8'hA7, 8'h00, 0, 2, 5);  // R10 narrow mask
      apply(0, 0, 8'h12, 8'h34, 0, 0, 0);   // R12 idle
      apply(1, 13, 8'h12, 8'h34, 0, 0, 0);  // R12 unused opcode
      for (int i = 0; i < 600; i++) begin
         apply(($urandom % 10) != 0, int'($urandom % 16), 8'($urandom), 8'($urandom),
               1'($urandom), int'($urandom % 8), int'($urandom % 8));
      end
      for (int i = 0; i < 60; i++) begin
         apply(1, int'($urandom % 2), (i % 2) ? 8'hFF : 8'h00, 8'($urandom % 2), 1, 0, 0);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule